// File: doc/BRIEF.md
# Quadratic Bezier Point Generator

This block walks a quadratic Bezier curve and hands out the pixel positions it passes through. A curve is given as three control points, each with an X and a Y in signed fixed point (integer part and fraction part set by parameters). The block sweeps the curve parameter from 0 to 1 in equal small steps. At each step a two-stage pipelined datapath blends the control points. Each coordinate is then clamped to an 8-bit pixel value.

Consecutive steps often land on the same pixel. Only steps that move to a new pixel are offered downstream, so a beam or pen driven from the output dwells equally on every pixel of the curve. The time between offered points therefore varies. Points are offered with a valid/ready pair, and a one-cycle done pulse marks the end of the curve. A new curve is started by a single-cycle `in_val` strobe while the block is idle.

Top module: `qbz_curve_stepper`

## Requirements
- R1: After reset, `out_val` and `done` are 0 and the block is idle.
- R2: A cycle with `in_val` high while idle latches the three control points and starts a curve. `in_val` is ignored while a curve is in progress, and the point sequence of that curve is unaffected.
- R3: For parameter t, the weights are computed and each is truncated to FRAC_W fraction bits: a=(1-t)^2, b=2*(1-t)*t (doubling applied after truncation), and c=t^2. A coordinate is a*P0+b*P1+c*P2, shifted right arithmetically by FRAC_W (floor).
- R4: t takes every value k*2^-STEP_LOG2 for k = 0 .. 2^STEP_LOG2, both ends included. The default is 513 values in steps of 1/512.
- R5: The pixel value of a coordinate is its integer part, clamped. A negative coordinate gives 0, a coordinate of 256 or more gives 255, and any other coordinate gives its integer part, 0..255.
- R6: The point at t = 0 is always offered.
- R7: Any later point is offered only if its pixel X or pixel Y differs from the last offered point. The offered points appear in order of increasing t.
- R8: While `out_val` is high and `out_rdy` is low, `out_val` stays high and `out_x`/`out_y` hold their values.
- R9: Once the point at t = 1 has been evaluated, and accepted if it was offered, `done` is high for exactly one cycle. The block is then idle with no points left to offer.
- R10: Starting a curve clears the memory of the last offered point. The first point of a new curve is offered even if it equals the last point of the previous curve.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_val | input | 1 | Start strobe, sampled while idle |
| in_x0 | input | INT_W+FRAC_W | Start control point X, signed fixed point |
| in_y0 | input | INT_W+FRAC_W | Start control point Y |
| in_x1 | input | INT_W+FRAC_W | Middle control point X |
| in_y1 | input | INT_W+FRAC_W | Middle control point Y |
| in_x2 | input | INT_W+FRAC_W | End control point X |
| in_y2 | input | INT_W+FRAC_W | End control point Y |
| out_val | output | 1 | A pixel point is offered |
| out_rdy | input | 1 | Downstream accepts the offered point |
| out_x | output | 8 | Offered pixel X |
| out_y | output | 8 | Offered pixel Y |
| done | output | 1 | One-cycle pulse at the end of a curve |

## Verification
The bench builds the block with its default parameters: 10 integer bits, 18 fraction bits and a 1/512 step. This gives full 513-step curves that can reach past both clamp limits, because control points span -512 to +511. The curves include normal arcs, arcs that overshoot 0 and 255 on both axes, a single repeated point, a straight horizontal run, and a curve starting on the previous curve's last pixel. Random backpressure stalls the pipeline in the middle of a sweep.

// File: rtl/qbz_pkg.sv
package qbz_pkg;

    localparam int PIX_W = 8;

    typedef logic [PIX_W-1:0] pix_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STEP  = 2'd1,
        ST_OFFER = 2'd2
    } qbz_state_e;

    function automatic logic pix_moved(input logic first,
                                       input pix_t nx, input pix_t ny,
                                       input pix_t ox, input pix_t oy);
        return first || (nx != ox) || (ny != oy);
    endfunction

endpackage

// File: rtl/qbz_weight_gen.sv
module qbz_weight_gen #(
    parameter int FRAC_W = 18,
    localparam int TW = FRAC_W + 1
) (
    input  logic          clk,
    input  logic          adv,
    input  logic [TW-1:0] t,
    output logic [TW-1:0] w0,
    output logic [TW-1:0] w1,
    output logic [TW-1:0] w2
);
    localparam logic [TW-1:0] ONE = TW'(1) << FRAC_W;

    logic [TW-1:0]   u;
    logic [2*TW-1:0] uu, ut, tt;

    assign u  = ONE - t;
    assign uu = u * u;
    assign ut = u * t;
    assign tt = t * t;

    // first multiply stage; doubling of the middle weight is a shift
    always_ff @(posedge clk) begin
        if (adv) begin
            w0 <= TW'(uu >> FRAC_W);
            w1 <= TW'((ut >> FRAC_W) << 1);
            w2 <= TW'(tt >> FRAC_W);
        end
    end
endmodule

// File: rtl/qbz_blend.sv
module qbz_blend #(
    parameter int INT_W  = 10,
    parameter int FRAC_W = 18,
    localparam int TW = FRAC_W + 1,
    localparam int CW = INT_W + FRAC_W
) (
    input  logic                 clk,
    input  logic                 adv,
    input  logic [TW-1:0]        w0,
    input  logic [TW-1:0]        w1,
    input  logic [TW-1:0]        w2,
    input  logic signed [CW-1:0] p0,
    input  logic signed [CW-1:0] p1,
    input  logic signed [CW-1:0] p2,
    output logic signed [CW-1:0] res
);
    localparam int PW = CW + TW + 1;
    localparam int SW = PW + 2;

    logic signed [PW-1:0] m0, m1, m2;
    logic signed [SW-1:0] acc;

    assign m0  = $signed({1'b0, w0}) * p0;
    assign m1  = $signed({1'b0, w1}) * p1;
    assign m2  = $signed({1'b0, w2}) * p2;
    assign acc = SW'(m0) + SW'(m1) + SW'(m2);

    // second multiply stage; weights sum to at most one, so no wrap
    always_ff @(posedge clk) begin
        if (adv) res <= CW'(acc >>> FRAC_W);
    end
endmodule

// File: rtl/qbz_sat.sv
module qbz_sat
    import qbz_pkg::*;
#(
    parameter int INT_W  = 10,
    parameter int FRAC_W = 18,
    localparam int CW = INT_W + FRAC_W
) (
    input  logic signed [CW-1:0] v,
    output pix_t                 pix
);
    logic neg, ovf;

    assign neg = v[CW-1];
    assign ovf = |v[CW-2:FRAC_W+PIX_W];

    always_comb begin
        if (neg)      pix = '0;
        else if (ovf) pix = '1;
        else          pix = PIX_W'(v >> FRAC_W);
    end
endmodule

// File: rtl/qbz_curve_stepper.sv
module qbz_curve_stepper
    import qbz_pkg::*;
#(
    parameter int INT_W     = 10,
    parameter int FRAC_W    = 18,
    parameter int STEP_LOG2 = 9
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            in_val,
    input  logic signed [INT_W+FRAC_W-1:0]  in_x0,
    input  logic signed [INT_W+FRAC_W-1:0]  in_y0,
    input  logic signed [INT_W+FRAC_W-1:0]  in_x1,
    input  logic signed [INT_W+FRAC_W-1:0]  in_y1,
    input  logic signed [INT_W+FRAC_W-1:0]  in_x2,
    input  logic signed [INT_W+FRAC_W-1:0]  in_y2,
    output logic                            out_val,
    input  logic                            out_rdy,
    output logic [7:0]                      out_x,
    output logic [7:0]                      out_y,
    output logic                            done
);
    localparam int CW = INT_W + FRAC_W;
    localparam int TW = FRAC_W + 1;
    localparam logic [TW-1:0] ONE      = TW'(1) << FRAC_W;
    localparam logic [TW-1:0] STEP_INC = TW'(1) << (FRAC_W - STEP_LOG2);

    qbz_state_e state_q;
    logic signed [CW-1:0] cp_q [2][3];
    logic [TW-1:0] t_q;
    logic          issuing_q;
    logic          v1_q, l1_q, v2_q, l2_q;
    logic          first_q, fin_q, done_q;
    pix_t          ox_q, oy_q;

    logic [TW-1:0]        w0, w1, w2;
    logic signed [CW-1:0] res [2];
    pix_t                 pix [2];
    logic                 adv, moved, start;

    assign adv   = (state_q == ST_STEP);
    assign start = (state_q == ST_IDLE) && in_val;
    assign moved = pix_moved(first_q, pix[0], pix[1], ox_q, oy_q);

    qbz_weight_gen #(.FRAC_W(FRAC_W)) u_wgen (
        .clk(clk), .adv(adv), .t(t_q), .w0(w0), .w1(w1), .w2(w2)
    );

    for (genvar a = 0; a < 2; a++) begin : g_axis
        qbz_blend #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_blend (
            .clk(clk), .adv(adv), .w0(w0), .w1(w1), .w2(w2),
            .p0(cp_q[a][0]), .p1(cp_q[a][1]), .p2(cp_q[a][2]),
            .res(res[a])
        );
        qbz_sat #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_sat (
            .v(res[a]), .pix(pix[a])
        );
    end

    // control points are captured only on a start strobe
    always_ff @(posedge clk) begin
        if (start) begin
            cp_q[0][0] <= in_x0; cp_q[0][1] <= in_x1; cp_q[0][2] <= in_x2;
            cp_q[1][0] <= in_y0; cp_q[1][1] <= in_y1; cp_q[1][2] <= in_y2;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            t_q       <= '0;
            issuing_q <= 1'b0;
            v1_q      <= 1'b0;
            l1_q      <= 1'b0;
            v2_q      <= 1'b0;
            l2_q      <= 1'b0;
            first_q   <= 1'b0;
            fin_q     <= 1'b0;
            done_q    <= 1'b0;
            ox_q      <= '0;
            oy_q      <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (in_val) begin
                        t_q       <= '0;
                        issuing_q <= 1'b1;
                        v1_q      <= 1'b0;
                        l1_q      <= 1'b0;
                        v2_q      <= 1'b0;
                        l2_q      <= 1'b0;
                        first_q   <= 1'b1;
                        fin_q     <= 1'b0;
                        ox_q      <= '0;
                        oy_q      <= '0;
                        state_q   <= ST_STEP;
                    end
                end
                ST_STEP: begin
                    if (issuing_q) begin
                        if (t_q == ONE) issuing_q <= 1'b0;
                        else            t_q <= t_q + STEP_INC;
                    end
                    v1_q <= issuing_q;
                    l1_q <= issuing_q && (t_q == ONE);
                    v2_q <= v1_q;
                    l2_q <= l1_q;
                    if (v2_q) begin
                        if (moved) begin
                            ox_q    <= pix[0];
                            oy_q    <= pix[1];
                            first_q <= 1'b0;
                            fin_q   <= l2_q;
                            state_q <= ST_OFFER;
                        end else if (l2_q) begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_OFFER: begin
                    if (out_rdy) begin
                        if (fin_q) begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            state_q <= ST_STEP;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign out_val = (state_q == ST_OFFER);
    assign out_x   = ox_q;
    assign out_y   = oy_q;
    assign done    = done_q;

    // checker state: last accepted point of the current curve
    logic pa_v;
    pix_t pa_x, pa_y;
    always_ff @(posedge clk) begin
        if (rst || start) begin
            pa_v <= 1'b0;
            pa_x <= '0;
            pa_y <= '0;
        end else if (out_val && out_rdy) begin
            pa_v <= 1'b1;
            pa_x <= out_x;
            pa_y <= out_y;
        end
    end

    p_ctrl_frozen_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> ($stable(cp_q[0][0]) && $stable(cp_q[0][1]) &&
                                  $stable(cp_q[0][2]) && $stable(cp_q[1][0]) &&
                                  $stable(cp_q[1][1]) && $stable(cp_q[1][2])));

    p_fresh_pixel_r7: assert property (@(posedge clk) disable iff (rst)
        ($rose(out_val) && pa_v) |-> ((out_x != pa_x) || (out_y != pa_y)));

    p_offer_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (out_val && !out_rdy) |=> (out_val && $stable(out_x) && $stable(out_y)));

    p_done_clean_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> (!out_val && $past(state_q != ST_IDLE)));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: tb/tb_qbz_curve_stepper.sv
module tb_qbz_curve_stepper;
    localparam int  INT_W      = 10;
    localparam int  FRAC_W     = 18;
    localparam int  STEP_LOG2  = 9;
    localparam int  CW         = INT_W + FRAC_W;
    localparam int  NSTEP      = 1 << STEP_LOG2;
    localparam time CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_val = 1'b0;
    logic signed [CW-1:0] in_x0 = '0, in_y0 = '0, in_x1 = '0, in_y1 = '0, in_x2 = '0, in_y2 = '0;
    logic out_val, out_rdy = 1'b1, done;
    logic [7:0] out_x, out_y;

    int checks = 0;
    int fails  = 0;
    int done_cnt = 0;
    bit rdy_rand = 1'b0;
    logic [15:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    qbz_curve_stepper #(.INT_W(INT_W), .FRAC_W(FRAC_W), .STEP_LOG2(STEP_LOG2)) dut (
        .clk(clk), .rst(rst), .in_val(in_val),
        .in_x0(in_x0), .in_y0(in_y0), .in_x1(in_x1), .in_y1(in_y1),
        .in_x2(in_x2), .in_y2(in_y2),
        .out_val(out_val), .out_rdy(out_rdy), .out_x(out_x), .out_y(out_y),
        .done(done)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    function automatic longint fx(int ip, int fr);
        return (longint'(ip) <<< FRAC_W) + longint'(fr);
    endfunction

    // R3 R4 R5: reference pixel for step k
    function automatic logic [7:0] pix_at(longint a, longint b, longint c, int k);
        longint one, t, u, w0, w1, w2, s, ip;
        one = longint'(1) <<< FRAC_W;
        t   = longint'(k) <<< (FRAC_W - STEP_LOG2);
        u   = one - t;
        w0  = (u * u) >>> FRAC_W;
        w1  = ((u * t) >>> FRAC_W) <<< 1;
        w2  = (t * t) >>> FRAC_W;
        s   = (w0 * a + w1 * b + w2 * c) >>> FRAC_W;
        ip  = s >>> FRAC_W;
        if (ip < 0)   return 8'd0;
        if (ip > 255) return 8'd255;
        return ip[7:0];
    endfunction

    task automatic run_curve(longint x0, longint y0, longint x1, longint y1,
                             longint x2, longint y2, bit poke);
        logic [7:0] lx, ly;
        int d0;
        lx = '0; ly = '0;
        for (int k = 0; k <= NSTEP; k++) begin
            logic [7:0] px, py;
            px = pix_at(x0, x1, x2, k);
            py = pix_at(y0, y1, y2, k);
            if (k == 0 || px != lx || py != ly) exp_q.push_back({px, py}); // R6 R7 R10
            lx = px; ly = py;
        end
        d0 = done_cnt;
        in_x0 = x0[CW-1:0]; in_y0 = y0[CW-1:0];
        in_x1 = x1[CW-1:0]; in_y1 = y1[CW-1:0];
        in_x2 = x2[CW-1:0]; in_y2 = y2[CW-1:0];
        in_val = 1'b1;
        tick();
        in_val = 1'b0;
        if (poke) begin // R2: strobe while busy must change nothing
            repeat (30) tick();
            in_x0 = fx(5, 0)[CW-1:0]; in_y0 = fx(250, 0)[CW-1:0];
            in_x1 = fx(-40, 0)[CW-1:0]; in_x2 = fx(300, 0)[CW-1:0];
            in_val = 1'b1;
            repeat (4) tick();
            in_val = 1'b0;
        end
        while (done_cnt == d0) tick();
        tick();
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R9: %0d points still expected at done, expected 0", exp_q.size());
            exp_q.delete();
        end
    endtask

    // ready driver
    initial begin
        forever begin
            @(posedge clk);
            #2;
            out_rdy = rdy_rand ? (($urandom % 3) == 0) : 1'b1;
        end
    end

    // monitor / scoreboard
    bit   prev_stall = 1'b0;
    bit   prev_done  = 1'b0;
    logic [7:0] sx, sy;
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_stall) begin
                checks++;
                if (!out_val || out_x != sx || out_y != sy) begin
                    fails++;
                    $display("FAIL R8: stalled offer became val=%0b (%0d,%0d), expected val=1 (%0d,%0d)",
                             out_val, out_x, out_y, sx, sy);
                end
            end
            prev_stall = out_val && !out_rdy;
            sx = out_x; sy = out_y;
            if (out_val && out_rdy) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R7: extra point (%0d,%0d), expected none", out_x, out_y);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    if ({out_x, out_y} != e) begin
                        fails++;
                        $display("FAIL R3 R5 R7: point (%0d,%0d), expected (%0d,%0d)",
                                 out_x, out_y, e[15:8], e[7:0]);
                    end
                end
            end
            if (done) begin
                done_cnt++;
                checks++;
                if (prev_done || out_val) begin
                    fails++;
                    $display("FAIL R9: done with prev_done=%0b out_val=%0b, expected 0 0",
                             prev_done, out_val);
                end
            end
            prev_done = done;
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R9: watchdog expired, expected curve completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        checks++; // R1
        if (out_val !== 1'b0 || done !== 1'b0) begin
            fails++;
            $display("FAIL R1: out_val=%0b done=%0b, expected 0 0", out_val, done);
        end
        // R3 R4: in-range arc, in_val poked while busy (R2)
        run_curve(fx(20, 1000), fx(30, 77000), fx(200, 0), fx(240, 131072),
                  fx(230, 5), fx(40, 200000), 1'b1);
        // R5: overshoot on both rails, with backpressure (R8)
        rdy_rand = 1'b1;
        run_curve(fx(-100, 0), fx(300, 0), fx(128, 0), fx(-200, 0),
                  fx(400, 0), fx(128, 0), 1'b1);
        // R7: all control points equal -> a single point
        rdy_rand = 1'b0;
        run_curve(fx(77, 3), fx(77, 9), fx(77, 3), fx(77, 9),
                  fx(77, 3), fx(77, 9), 1'b0);
        // R10: next curve begins on the same pixel
        rdy_rand = 1'b1;
        run_curve(fx(77, 0), fx(77, 0), fx(150, 0), fx(10, 0),
                  fx(240, 0), fx(200, 0), 1'b0);
        // R7: horizontal run, only X changes
        rdy_rand = 1'b0;
        run_curve(fx(10, 0), fx(100, 0), fx(128, 0), fx(100, 0),
                  fx(250, 0), fx(100, 0), 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule